// File: doc/BRIEF.md
# DSI Generic Register Access Decoder

This block sits behind the lane logic of a display-link receiver. It takes packet bytes that have already been deserialized and aligned, one byte per accepted cycle, with a marker on the first byte of each packet. It turns two kinds of packets into accesses on a 32-bit register bus with 16-bit byte addresses. A generic long write carries a register address and then one or more 32-bit data words. Each word becomes a single-cycle write strobe, and every further word goes to the next register.

A generic read request carries the register address in the two parameter bytes of the packet header. The block raises a read request on the register bus and holds it until the read data returns. It then places a 4-byte read response into a one-entry buffer. That buffer is held until the link grants a bus turnaround. The lane logic serializes the response and adds ECC and checksum.

Packets are accepted only on the configured virtual channel. A malformed write length, or a read that arrives while another read is still outstanding, sets a sticky error flag.

Top module: `dsi_reg_decoder`

## Requirements
- R1: A packet whose first byte has data type 0x29 (bits 5:0) on the configured channel is a register write. Payload bytes 0 and 1 give the address, low byte first. Each following group of four bytes is a data word, least significant byte first. Each word produces a one-cycle `wr_valid` strobe with `wr_addr`/`wr_data` in the cycle after its last byte is accepted.
- R2: Each extra word in one write packet is written to the previous address plus 4, wrapping modulo 2^16.
- R3: A write packet whose word count (header bytes 1 and 2, low byte first) is below 6, or whose word count minus 2 is not a multiple of 4, issues no write. It sets `err_flag`, which stays set until reset.
- R4: When a new packet starts before the four bytes of a data word have arrived, no write is issued for the partial word.
- R5: A packet whose virtual channel (first byte, bits 7:6) differs from `own_vc` causes neither a write nor a read.
- R6: A packet with data type 0x24 on the configured channel raises `rd_req`, with `rd_addr` = {second parameter byte, first parameter byte}. The request is held, with its address stable, until `rd_data_valid`.
- R7: After `rd_data_valid`, `rsp_valid` rises in the next cycle. At that point `rsp_di` = {request channel, 0x1A}, `rsp_wc` = 4 and `rsp_data` = the returned word. The response is held until `ta_grant`, and `rsp_valid` clears in the cycle after the grant.
- R8: A read request whose header completes while a read is pending or a response is held is dropped: no new `rd_req` is raised and `err_flag` is set.
- R9: Checksum bytes after the write payload, and packets of any other data type, cause no bus activity.
- R10: After reset, `wr_valid`, `rd_req`, `rsp_valid` and `err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_vc | input | 2 | Virtual channel this block answers on |
| in_valid | input | 1 | Packet byte valid |
| in_sop | input | 1 | Byte is the first of a packet |
| in_byte | input | 8 | Packet byte |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 16 | Register write byte address |
| wr_data | output | 32 | Register write data |
| rd_req | output | 1 | Register read request, held until data returns |
| rd_addr | output | 16 | Register read byte address |
| rd_data_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data |
| rsp_valid | output | 1 | Read response buffered |
| rsp_di | output | 8 | Response identifier byte (channel and data type) |
| rsp_wc | output | 16 | Response word count |
| rsp_data | output | 32 | Response payload |
| ta_grant | input | 1 | Turnaround granted; response taken |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 32-bit word and an address step of 4. With a 16-bit address, a three-word write that starts at 0xFFF8 crosses the top of the address space within one packet, so the wrap is tested directly. Byte gaps within a packet, truncation in the middle of a word, channel changes and read-response back-pressure all run against a scoreboard of expected writes. That scoreboard also catches any write that was not expected.

// File: rtl/dsigr_pkg.sv
package dsigr_pkg;
  localparam int VC_W = 2;
  localparam int DT_W = 6;

  typedef logic [DT_W-1:0] dtype_t;

  localparam dtype_t DT_GEN_LWRITE = 6'h29;
  localparam dtype_t DT_GEN_READ2  = 6'h24;
  localparam dtype_t DT_RD_RESP    = 6'h1A;

  typedef enum logic [2:0] {H_IDLE, H_P1, H_P2, H_ECC, H_BODY} hstate_e;

  // legal write length: address bytes plus a whole, non-zero number of words
  function automatic logic wc_is_legal(input logic [15:0] wc, input int addr_bytes,
                                       input int word_bytes);
    int n;
    n = int'(wc);
    return (n >= addr_bytes + word_bytes) && (((n - addr_bytes) % word_bytes) == 0);
  endfunction

  function automatic logic [31:0] next_reg_addr(input logic [31:0] a, input int step);
    return a + 32'(step);
  endfunction
endpackage

// File: rtl/dsigr_hdr.sv
module dsigr_hdr
  import dsigr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic [7:0]      in_byte,
  output logic            pkt_start,
  output logic            hdr_done,
  output logic            pay_valid,
  output logic [VC_W-1:0] hdr_vc,
  output dtype_t          hdr_dt,
  output logic [7:0]      hdr_p1,
  output logic [7:0]      hdr_p2
);
  hstate_e    st;
  logic [7:0] di_q, p1_q, p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= H_IDLE;
      di_q <= '0;
      p1_q <= '0;
      p2_q <= '0;
    end else if (in_valid) begin
      if (in_sop) begin
        di_q <= in_byte;
        st   <= H_P1;
      end else begin
        case (st)
          H_P1:    begin p1_q <= in_byte; st <= H_P2; end
          H_P2:    begin p2_q <= in_byte; st <= H_ECC; end
          H_ECC:   st <= H_BODY;
          default: st <= st;
        endcase
      end
    end
  end

  assign pkt_start = in_valid & in_sop;
  assign hdr_done  = in_valid & ~in_sop & (st == H_ECC);
  assign pay_valid = in_valid & ~in_sop & (st == H_BODY);
  assign hdr_vc    = di_q[7:8-VC_W];
  assign hdr_dt    = di_q[DT_W-1:0];
  assign hdr_p1    = p1_q;
  assign hdr_p2    = p2_q;
endmodule

// File: rtl/dsigr_wr.sv
module dsigr_wr
  import dsigr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WC_W      = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VC_W-1:0]   own_vc,
  input  logic              pkt_start,
  input  logic              hdr_done,
  input  logic [VC_W-1:0]   hdr_vc,
  input  dtype_t            hdr_dt,
  input  logic [WC_W-1:0]   hdr_wc,
  input  logic              pay_valid,
  input  logic [7:0]        pay_byte,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              len_err
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int PH_W       = $clog2(WORD_BYTES);

  logic                            active;
  logic [WC_W-1:0]                 wc_q, bidx;
  logic [ADDR_W-1:0]               addr_q;
  logic [WORD_BYTES-2:0][7:0]      wbuf;
  logic                            take, legal, in_addr, word_last, fire;
  logic [PH_W-1:0]                 phase;

  assign take      = hdr_done && (hdr_vc == own_vc) && (hdr_dt == DT_GEN_LWRITE);
  assign legal     = wc_is_legal(16'(hdr_wc), ADDR_BYTES, WORD_BYTES);
  assign len_err   = take & ~legal;
  assign in_addr   = (bidx < WC_W'(ADDR_BYTES));
  assign phase     = PH_W'(bidx - WC_W'(ADDR_BYTES));
  assign word_last = (phase == PH_W'(WORD_BYTES - 1));
  assign fire      = pay_valid & active & ~in_addr & word_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wc_q     <= '0;
      bidx     <= '0;
      addr_q   <= '0;
      wbuf     <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (pkt_start) begin
        active <= 1'b0;
      end else if (hdr_done) begin
        active <= take & legal;
        wc_q   <= hdr_wc;
        bidx   <= '0;
      end else if (pay_valid && active) begin
        bidx <= bidx + 1'b1;
        if (bidx + 1'b1 == wc_q) active <= 1'b0;
        if (in_addr) begin
          for (int i = 0; i < ADDR_BYTES; i++)
            if (bidx == WC_W'(i)) addr_q[8*i +: 8] <= pay_byte;
        end else if (word_last) begin
          wr_valid <= 1'b1;
          wr_addr  <= addr_q;
          wr_data  <= {pay_byte, wbuf};
          addr_q   <= ADDR_W'(next_reg_addr(32'(addr_q), ADDR_STEP));
        end else begin
          for (int j = 0; j < WORD_BYTES - 1; j++)
            if (phase == PH_W'(j)) wbuf[j] <= pay_byte;
        end
      end
    end
  end

  // R1: a word needs several bytes, so strobes never run back to back
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4: a word completing means the packet is still the active write
  a_r4_fire_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wr_valid);
endmodule

// File: rtl/dsigr_rd.sv
module dsigr_rd
  import dsigr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VC_W-1:0]   own_vc,
  input  logic              hdr_done,
  input  logic [VC_W-1:0]   hdr_vc,
  input  dtype_t            hdr_dt,
  input  logic [7:0]        hdr_p1,
  input  logic [7:0]        hdr_p2,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [7:0]        rsp_di,
  output logic [WC_W-1:0]   rsp_wc,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ta_grant,
  output logic              busy_err
);
  logic              pend_q, full_q, want, busy;
  logic [VC_W-1:0]   vc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign want     = hdr_done && (hdr_vc == own_vc) && (hdr_dt == DT_GEN_READ2);
  assign busy     = pend_q | full_q;
  assign busy_err = want & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      full_q <= 1'b0;
      vc_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (want && !busy) begin
        pend_q <= 1'b1;
        vc_q   <= hdr_vc;
        addr_q <= ADDR_W'({hdr_p2, hdr_p1});
      end else if (pend_q && rd_data_valid) begin
        pend_q <= 1'b0;
        full_q <= 1'b1;
        data_q <= rd_data;
      end
      if (full_q && ta_grant) full_q <= 1'b0;
    end
  end

  assign rd_req    = pend_q;
  assign rd_addr   = addr_q;
  assign rsp_valid = full_q;
  assign rsp_di    = {vc_q, DT_RD_RESP};
  assign rsp_wc    = WC_W'(DATA_W / 8);
  assign rsp_data  = data_q;

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_data_valid) |=> (rd_req && $stable(rd_addr)));
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !ta_grant) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_di)));
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && rsp_valid));
endmodule

// File: rtl/dsi_reg_decoder.sv
module dsi_reg_decoder
  import dsigr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WC_W      = 16,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        own_vc,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_byte,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [7:0]        rsp_di,
  output logic [WC_W-1:0]   rsp_wc,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ta_grant,
  output logic              err_flag
);
  logic            pkt_start, hdr_done, pay_valid, len_err, busy_err;
  logic [VC_W-1:0] hdr_vc;
  dtype_t          hdr_dt;
  logic [7:0]      hdr_p1, hdr_p2;

  dsigr_hdr u_hdr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .pkt_start(pkt_start), .hdr_done(hdr_done), .pay_valid(pay_valid),
    .hdr_vc(hdr_vc), .hdr_dt(hdr_dt), .hdr_p1(hdr_p1), .hdr_p2(hdr_p2)
  );

  dsigr_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WC_W(WC_W), .ADDR_STEP(ADDR_STEP)) u_wr (
    .clk(clk), .rst_n(rst_n), .own_vc(own_vc), .pkt_start(pkt_start),
    .hdr_done(hdr_done), .hdr_vc(hdr_vc), .hdr_dt(hdr_dt),
    .hdr_wc(WC_W'({hdr_p2, hdr_p1})), .pay_valid(pay_valid), .pay_byte(in_byte),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .len_err(len_err)
  );

  dsigr_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WC_W(WC_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .own_vc(own_vc), .hdr_done(hdr_done),
    .hdr_vc(hdr_vc), .hdr_dt(hdr_dt), .hdr_p1(hdr_p1), .hdr_p2(hdr_p2),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_di(rsp_di), .rsp_wc(rsp_wc), .rsp_data(rsp_data),
    .ta_grant(ta_grant), .busy_err(busy_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_flag <= 1'b0;
    else if (len_err || busy_err) err_flag <= 1'b1;
  end

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r3_len_err_raises: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> err_flag);
endmodule

// File: tb/tb_dsi_reg_decoder.sv
module tb_dsi_reg_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  own_vc = 2'd0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        wr_valid, rd_req, rsp_valid, err_flag;
  logic [15:0] wr_addr, rd_addr, rsp_wc;
  logic [31:0] wr_data, rsp_data;
  logic [7:0]  rsp_di;
  logic        rd_data_valid = 1'b0, ta_grant = 1'b0;
  logic [31:0] rd_data = '0;

  int n_checks = 0, n_fail = 0, wr_seen = 0;

  typedef struct { logic [15:0] a; logic [31:0] d; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsi_reg_decoder dut (
    .clk(clk), .rst_n(rst_n), .own_vc(own_vc), .in_valid(in_valid), .in_sop(in_sop),
    .in_byte(in_byte), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_di(rsp_di), .rsp_wc(rsp_wc), .rsp_data(rsp_data),
    .ta_grant(ta_grant), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      wr_seen++;
      n_checks++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R5/R9 unexpected write: actual %h@%h expected none", wr_data, wr_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (wr_addr !== e.a || wr_data !== e.d) begin
          n_fail++;
          $display("FAIL %s: actual %h@%h expected %h@%h", e.tag, wr_data, wr_addr, e.d, e.a);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input logic s);
    @(negedge clk); in_valid = 1'b1; in_sop = s; in_byte = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; end
  endtask

  task automatic gap_if(input bit g);
    if (g) begin @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; end
  endtask

  task automatic wr_pkt(input logic [1:0] vc, input logic [15:0] addr, input int n,
                        input logic [31:0] base, input bit expect_wr, input bit gap,
                        input string tag);
    logic [15:0] wc;
    wc = 16'(2 + 4 * n);
    for (int k = 0; k < n; k++)
      if (expect_wr) q.push_back('{addr + 16'(4 * k), base + 32'(k) * 32'h0102_0304, tag});
    put({vc, 6'h29}, 1'b1); put(wc[7:0], 1'b0); put(wc[15:8], 1'b0); put(8'h00, 1'b0);
    put(addr[7:0], 1'b0); gap_if(gap); put(addr[15:8], 1'b0); gap_if(gap);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      w = base + 32'(k) * 32'h0102_0304;
      for (int b = 0; b < 4; b++) begin put(w[8*b +: 8], 1'b0); gap_if(gap); end
    end
    put(8'hA5, 1'b0); put(8'h5A, 1'b0);   // checksum bytes (R9)
    idle(2);
  endtask

  task automatic rd_pkt(input logic [1:0] vc, input logic [15:0] addr);
    put({vc, 6'h24}, 1'b1); put(addr[7:0], 1'b0); put(addr[15:8], 1'b0); put(8'h00, 1'b0);
    idle(1);
  endtask

  task automatic rd_serve(input logic [1:0] vc, input logic [15:0] addr,
                          input logic [31:0] data, input int delay);
    chk("R6 rd_req raised", 32'(rd_req), 32'd1);
    chk("R6 rd_addr", 32'(rd_addr), 32'(addr));
    repeat (delay) begin
      @(negedge clk);
      chk("R6 rd_req held", 32'(rd_req), 32'd1);
    end
    @(negedge clk); rd_data_valid = 1'b1; rd_data = data;
    @(negedge clk); rd_data_valid = 1'b0;
    chk("R7 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R7 rsp_di", 32'(rsp_di), 32'({vc, 6'h1A}));
    chk("R7 rsp_wc", 32'(rsp_wc), 32'd4);
    chk("R7 rsp_data", rsp_data, data);
    chk("R7 rd_req dropped", 32'(rd_req), 32'd0);
  endtask

  task automatic grant();
    @(negedge clk); ta_grant = 1'b1;
    @(negedge clk); ta_grant = 1'b0;
    chk("R7 rsp cleared after grant", 32'(rsp_valid), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 wr_valid", 32'(wr_valid), 32'd0);
    chk("R10 rd_req", 32'(rd_req), 32'd0);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 err_flag", 32'(err_flag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base_seen;
    do_reset();

    // R1: single word, then R2: several words with gaps and an address wrap
    wr_pkt(2'd0, 16'h0450, 1, 32'h0100_0120, 1'b1, 1'b0, "R1 single write");
    wr_pkt(2'd0, 16'h0480, 3, 32'h0302_0100, 1'b1, 1'b1, "R2 multi write");
    wr_pkt(2'd0, 16'hFFF8, 3, 32'hDEAD_BEEF, 1'b1, 1'b0, "R2 address wrap");
    chk("R2 all writes seen", 32'(q.size()), 32'd0);

    // R4: a new packet starts midway through a data word
    put(8'h29, 1'b1); put(8'd10, 1'b0); put(8'd0, 1'b0); put(8'h00, 1'b0);
    put(8'h00, 1'b0); put(8'h01, 1'b0); put(8'h11, 1'b0); put(8'h22, 1'b0);
    wr_pkt(2'd0, 16'h0200, 1, 32'h5555_AAAA, 1'b1, 1'b0, "R4 write after truncation");
    chk("R4 only complete word written", 32'(q.size()), 32'd0);

    // R5: other channel ignored, then reconfigured channel accepted
    base_seen = wr_seen;
    wr_pkt(2'd1, 16'h0300, 2, 32'h1234_5678, 1'b0, 1'b0, "R5 foreign vc");
    chk("R5 no write on foreign vc", 32'(wr_seen - base_seen), 32'd0);
    rd_pkt(2'd2, 16'h0580);
    repeat (3) @(negedge clk);
    chk("R5 no read on foreign vc", 32'(rd_req), 32'd0);
    own_vc = 2'd1;
    wr_pkt(2'd1, 16'h0304, 1, 32'hCAFE_F00D, 1'b1, 1'b0, "R5 configured vc write");
    chk("R5 configured vc written", 32'(q.size()), 32'd0);

    // R9: other data types do nothing
    base_seen = wr_seen;
    put({2'd1, 6'h05}, 1'b1); put(8'h10, 1'b0); put(8'h00, 1'b0); put(8'h00, 1'b0);
    put({2'd1, 6'h39}, 1'b1); put(8'd6, 1'b0); put(8'd0, 1'b0); put(8'h00, 1'b0);
    for (int i = 0; i < 8; i++) put(8'(i), 1'b0);
    idle(3);
    chk("R9 no write for other types", 32'(wr_seen - base_seen), 32'd0);
    chk("R9 no read for other types", 32'(rd_req), 32'd0);

    // R6, R7: read with delayed data, response held until grant
    rd_pkt(2'd1, 16'h0580);
    rd_serve(2'd1, 16'h0580, 32'h0000_6500, 3);
    repeat (3) @(negedge clk);
    chk("R7 response held without grant", 32'(rsp_valid), 32'd1);
    grant();

    // R8: a read while a response is held is dropped and flagged
    chk("R8 err clear before", 32'(err_flag), 32'd0);
    rd_pkt(2'd1, 16'h0104);
    rd_serve(2'd1, 16'h0104, 32'h0000_0001, 0);
    rd_pkt(2'd1, 16'h0108);
    chk("R8 err set on busy read", 32'(err_flag), 32'd1);
    chk("R8 no new request", 32'(rd_req), 32'd0);
    chk("R8 first response kept", rsp_data, 32'h0000_0001);
    grant();
    repeat (2) @(negedge clk);
    chk("R8 dropped read stays dropped", 32'(rd_req), 32'd0);

    // R3: bad lengths, on a fresh reset
    do_reset();
    own_vc = 2'd0;
    base_seen = wr_seen;
    put(8'h29, 1'b1); put(8'd5, 1'b0); put(8'd0, 1'b0); put(8'h00, 1'b0);
    for (int i = 0; i < 5; i++) put(8'(i + 1), 1'b0);
    idle(2);
    chk("R3 err after wc 5", 32'(err_flag), 32'd1);
    put(8'h29, 1'b1); put(8'd8, 1'b0); put(8'd0, 1'b0); put(8'h00, 1'b0);
    for (int i = 0; i < 8; i++) put(8'(i + 1), 1'b0);
    idle(2);
    chk("R3 no write for bad lengths", 32'(wr_seen - base_seen), 32'd0);
    wr_pkt(2'd0, 16'h0010, 1, 32'h0BAD_0000, 1'b1, 1'b0, "R3 good write after error");
    chk("R3 err stays set", 32'(err_flag), 32'd1);
    chk("R3 queue drained", 32'(q.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule